// File: doc/BRIEF.md
# Sixteen-Code Arithmetic Logic Unit with Multiply

This block is the execute-stage arithmetic unit of a small RISC-V style datapath. It receives two operands and a four-bit operation code, and it returns one result word with no clock in its path. The operations are addition, subtraction, three kinds of shift, a signed less-than test, the three bitwise logic functions, the low word of a product, the signed and the unsigned high words of a product, and a pass-through of the second operand.

Every function unit works on the operands at the same time, and a final multiplexer keyed on the operation code picks one result. Addition, subtraction and the comparison share one adder. The three shifts share one right-shifting barrel, and left shifts reverse the word before and after it. All three multiply codes share one multiplier that is one bit wider than the operands, with the sign extension chosen by the code. Three codes have no operation, and they return zero so that the output is always defined.

Top module: `arith_logic_unit`

## Requirements
- R1: Code 0 (add) returns opnd_a + opnd_b modulo 2^32, with no overflow indication.
- R2: Code 12 (sub) returns opnd_a - opnd_b modulo 2^32.
- R3: Code 1 (sll) shifts opnd_a left by opnd_b[4:0] and fills with zeros. Bits 31:5 of opnd_b have no effect.
- R4: Code 5 (srl) shifts opnd_a right by opnd_b[4:0] and fills with zeros.
- R5: Code 13 (sra) shifts opnd_a right by opnd_b[4:0] and fills with copies of opnd_a[31].
- R6: Code 2 (slt) returns 1 when opnd_a is less than opnd_b as two's-complement values, and returns 0 otherwise.
- R7: Code 4 returns the bitwise XOR of the operands, code 6 returns the bitwise OR, and code 7 returns the bitwise AND.
- R8: Code 8 (mul) returns bits 31:0 of the product of the operands.
- R9: Code 9 (mulh) returns bits 63:32 of the product with both operands taken as signed.
- R10: Code 11 (mulhu) returns bits 63:32 of the product with both operands taken as unsigned.
- R11: Code 15 (bsel) returns opnd_b unchanged.
- R12: Codes 3, 10 and 14 return zero.
- R13: The result follows any change of an operand or of the code within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, which also supplies the shift amount |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Output of the selected operation |

## Verification
The bench builds the unit with its default 32-bit width. At this width the hand-computed expected values in the table apply directly: the sign-boundary products 0x80000000 squared and all-ones squared, shift amounts whose upper bits are set, and the wrap points of the adder. A sweep then runs every code over an 8-by-8 set of corner operands and compares each result with a 64-bit reference model. The sweep also covers the three unused codes and both directions of the signed comparison across the sign boundary.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SLL   = 4'd1,
    OP_SLT   = 4'd2,
    OP_RSV3  = 4'd3,
    OP_XOR   = 4'd4,
    OP_SRL   = 4'd5,
    OP_OR    = 4'd6,
    OP_AND   = 4'd7,
    OP_MUL   = 4'd8,
    OP_MULH  = 4'd9,
    OP_RSV10 = 4'd10,
    OP_MULHU = 4'd11,
    OP_SUB   = 4'd12,
    OP_SRA   = 4'd13,
    OP_RSV14 = 4'd14,
    OP_BSEL  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         subtract,
  output logic [W-1:0] sum_out,
  output logic         lt_signed
);
  logic [W-1:0] b_eff;
  logic         ovf;

  always_comb begin
    b_eff   = b_in ^ {W{subtract}};
    sum_out = a_in + b_eff + W'(subtract);
    // Signed overflow of a - b: operand signs differ and the difference sign
    // disagrees with a.
    ovf       = (a_in[W-1] != b_in[W-1]) && (sum_out[W-1] != a_in[W-1]);
    lt_signed = sum_out[W-1] ^ ovf;
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]         data_in,
  input  logic [$clog2(W)-1:0] amount,
  input  logic                 dir_left,
  input  logic                 arith,
  output logic [W-1:0]         data_out
);
  localparam int unsigned SH_W = $clog2(W);

  logic [W-1:0] reversed_in;
  logic [W-1:0] stage [SH_W+1];
  logic         fill_bit;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      reversed_in[i] = data_in[W-1-i];
    end
    fill_bit = arith & ~dir_left & data_in[W-1];
  end

  assign stage[0] = dir_left ? reversed_in : data_in;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stage[s+1] = amount[s]
                      ? {{STEP{fill_bit}}, stage[s][W-1:STEP]}
                      : stage[s];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      data_out[i] = dir_left ? stage[SH_W][W-1-i] : stage[SH_W][i];
    end
  end
endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         signed_ops,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi
);
  localparam int unsigned EXT_W  = W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;

  logic [EXT_W-1:0]  a_ext;
  logic [EXT_W-1:0]  b_ext;
  logic [PROD_W-1:0] product;

  always_comb begin
    a_ext   = {a_in[W-1] & signed_ops, a_in};
    b_ext   = {b_in[W-1] & signed_ops, b_in};
    product = $signed({{EXT_W{a_ext[EXT_W-1]}}, a_ext})
            * $signed({{EXT_W{b_ext[EXT_W-1]}}, b_ext});
    prod_lo = product[W-1:0];
    prod_hi = product[2*W-1:W];
  end
endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [OP_W-1:0] op_sel,
  output logic [W-1:0]    result
);
  localparam int unsigned SH_W = $clog2(W);

  alu_op_e      op;
  logic         do_sub;
  logic         shl;
  logic         sh_arith;
  logic         mul_signed;
  logic [W-1:0] sum_w;
  logic         lt_w;
  logic [W-1:0] shift_w;
  logic [W-1:0] lo_w;
  logic [W-1:0] hi_w;

  always_comb begin
    op         = alu_op_e'(op_sel);
    do_sub     = (op == OP_SUB) || (op == OP_SLT);
    shl        = (op == OP_SLL);
    sh_arith   = (op == OP_SRA);
    mul_signed = (op != OP_MULHU);
  end

  alu_addsub #(.W(W)) u_addsub (
    .a_in      (opnd_a),
    .b_in      (opnd_b),
    .subtract  (do_sub),
    .sum_out   (sum_w),
    .lt_signed (lt_w)
  );

  alu_shifter #(.W(W)) u_shifter (
    .data_in  (opnd_a),
    .amount   (opnd_b[SH_W-1:0]),
    .dir_left (shl),
    .arith    (sh_arith),
    .data_out (shift_w)
  );

  alu_multiplier #(.W(W)) u_mult (
    .a_in       (opnd_a),
    .b_in       (opnd_b),
    .signed_ops (mul_signed),
    .prod_lo    (lo_w),
    .prod_hi    (hi_w)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:           result = sum_w;
      OP_SLL, OP_SRL, OP_SRA:   result = shift_w;
      OP_SLT:                   result = {{(W-1){1'b0}}, lt_w};
      OP_XOR:                   result = opnd_a ^ opnd_b;
      OP_OR:                    result = opnd_a | opnd_b;
      OP_AND:                   result = opnd_a & opnd_b;
      OP_MUL:                   result = lo_w;
      OP_MULH, OP_MULHU:        result = hi_w;
      OP_BSEL:                  result = opnd_b;
      OP_RSV3, OP_RSV10, OP_RSV14: result = '0;
      default:                  result = '0;
    endcase
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic [W-1:0]    opnd_a,
  input logic [W-1:0]    opnd_b,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    result
);
  localparam int unsigned SH_W = $clog2(W);

  always_comb begin
    if (op_sel == OP_ADD)
      assert_add_inverse_R1: assert (result - opnd_b == opnd_a)
        else $error("add result inconsistent");
    if (op_sel == OP_SUB)
      assert_sub_inverse_R2: assert (result + opnd_b == opnd_a)
        else $error("sub result inconsistent");
    if (op_sel == OP_SLL && opnd_b[SH_W-1:0] != '0)
      assert_sll_low_zero_R3: assert (result[0] == 1'b0)
        else $error("sll low bit not zero");
    if (op_sel == OP_SRL && opnd_b[SH_W-1:0] != '0)
      assert_srl_top_zero_R4: assert (result[W-1] == 1'b0)
        else $error("srl top bit not zero");
    if (op_sel == OP_SRA)
      assert_sra_sign_kept_R5: assert (result[W-1] == opnd_a[W-1])
        else $error("sra sign lost");
    if (op_sel == OP_SLT)
      assert_slt_bool_R6: assert (result[W-1:1] == '0)
        else $error("slt not boolean");
    if (op_sel == OP_BSEL)
      assert_bsel_pass_R11: assert (result == opnd_b)
        else $error("bsel mismatch");
    if (op_sel == OP_RSV3 || op_sel == OP_RSV10 || op_sel == OP_RSV14)
      assert_unused_zero_R12: assert (result == '0)
        else $error("unused code nonzero");
  end
endmodule

bind arith_logic_unit alu_checker #(.W(W)) u_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .op_sel (op_sel),
  .result (result)
);

// File: tb/arith_logic_unit_tb.sv
module arith_logic_unit_tb;
  localparam int unsigned W  = 32;
  localparam int unsigned NV = 22;
  localparam int unsigned NC = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [3:0]   sel;
  logic [W-1:0] y;
  int           checks;
  int           failures;
  bit           done;

  arith_logic_unit #(.W(W)) u_dut (
    .opnd_a (a),
    .opnd_b (b),
    .op_sel (sel),
    .result (y)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {code, a, b, expected}
  localparam logic [99:0] TBL [NV] = '{
    {4'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {4'd12, 32'h00000000, 32'h00000001, 32'hFFFFFFFF},
    {4'd1,  32'h00000001, 32'h00000021, 32'h00000002},
    {4'd2,  32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {4'd2,  32'h00000001, 32'hFFFFFFFF, 32'h00000000},
    {4'd4,  32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0},
    {4'd5,  32'h80000000, 32'hFFFFFFE4, 32'h08000000},
    {4'd13, 32'h80000000, 32'h00000004, 32'hF8000000},
    {4'd6,  32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF},
    {4'd7,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
    {4'd8,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001},
    {4'd9,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    {4'd11, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},
    {4'd9,  32'h80000000, 32'h80000000, 32'h40000000},
    {4'd11, 32'h80000000, 32'h80000000, 32'h40000000},
    {4'd9,  32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF},
    {4'd11, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},
    {4'd15, 32'hDEADBEEF, 32'h12345678, 32'h12345678},
    {4'd3,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    {4'd10, 32'h12345678, 32'h9ABCDEF0, 32'h00000000},
    {4'd14, 32'h80000000, 32'h7FFFFFFF, 32'h00000000}
  };

  localparam logic [W-1:0] CORNER [NC] = '{
    32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFF,
    32'h80000000, 32'h0000001F, 32'hAAAAAAA5, 32'h12345678
  };

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd0:          return "R1";
      4'd12:         return "R2";
      4'd1:          return "R3";
      4'd5:          return "R4";
      4'd13:         return "R5";
      4'd2:          return "R6";
      4'd4, 4'd6, 4'd7: return "R7";
      4'd8:          return "R8";
      4'd9:          return "R9";
      4'd11:         return "R10";
      4'd15:         return "R11";
      default:       return "R12";
    endcase
  endfunction

  function automatic logic [W-1:0] ref_model(input logic [3:0] code,
                                             input logic [W-1:0] ra,
                                             input logic [W-1:0] rb);
    logic [63:0] sp;
    logic [63:0] up;
    logic [4:0]  sh;
    sp = 64'($signed(ra)) * 64'($signed(rb));
    up = {32'h0, ra} * {32'h0, rb};
    sh = rb[4:0];
    case (code)
      4'd0:  return ra + rb;
      4'd12: return ra - rb;
      4'd1:  return ra << sh;
      4'd5:  return ra >> sh;
      4'd13: return W'($signed(ra) >>> sh);
      4'd2:  return ($signed(ra) < $signed(rb)) ? 32'd1 : 32'd0;
      4'd4:  return ra ^ rb;
      4'd6:  return ra | rb;
      4'd7:  return ra & rb;
      4'd8:  return up[31:0];
      4'd9:  return sp[63:32];
      4'd11: return up[63:32];
      4'd15: return rb;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s code=%0d a=%h b=%h actual=%h expected=%h",
               req, sel, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] code, input logic [W-1:0] va,
                       input logic [W-1:0] vb);
    @(negedge clk);
    sel = code;
    a   = va;
    b   = vb;
    #1;
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    a        = '0;
    b        = '0;
    sel      = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", y, 32'h0);                 // all-zero inputs, add

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][99:96], TBL[i][95:64], TBL[i][63:32]);
      check(req_of(TBL[i][99:96]), y, TBL[i][31:0]);
    end

    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < NC; i++) begin
        for (int j = 0; j < NC; j++) begin
          apply(4'(c), CORNER[i], CORNER[j]);
          check(req_of(4'(c)), y, ref_model(4'(c), CORNER[i], CORNER[j]));
        end
      end
    end

    // R3: upper bits of the shift operand ignored
    apply(4'd1, 32'h00000003, 32'hFFFFFFE0);
    check("R3", y, 32'h00000003);
    // R5: zero amount leaves the word intact
    apply(4'd13, 32'h80000001, 32'h00000000);
    check("R5", y, 32'h80000001);
    // R13: result follows inputs inside one clock phase
    @(negedge clk);
    sel = 4'd0; a = 32'd5; b = 32'd6;
    #0.5;
    check("R13", y, 32'd11);
    sel = 4'd15;
    #0.5;
    check("R13", y, 32'd6);
    b = 32'd9;
    #0.5;
    check("R13", y, 32'd9);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule